// File: doc/BRIEF.md
# Halt Mode Power Controller

This block sequences the deepest stop mode of a small microcontroller. When the core executes its halt instruction, the controller checks two conditions. The first is an oscillator-interrupt-enable status bit. The second is a watchdog option. From these it decides whether to ignore the strobe, raise a watchdog reset, or stop. If it stops, the main oscillator, the CPU clock and the peripheral clock are all switched off. On the way in, it also forces the two interrupt-level bits so that interrupts are enabled.

The controller leaves halt on a synchronous external reset request or on an interrupt request that the wake mask allows. On wake-up it first turns the oscillator back on. It then keeps the CPU and peripherals stopped for a stabilisation count of either a short or a long number of cycles. The length is selected when halt is entered. After the count, it returns to run and emits a one-cycle resume pulse. That pulse tells the core whether to service the waking interrupt or to fetch the reset vector.

The stabilisation counter runs on the free-running oscillator-domain clock `clk_i`. Peripherals clocked from another source are not controlled here.

Top module: `halt_power_ctrl`

## Requirements
- R1: After reset the controller is in run. `osc_en_o`, `cpu_clk_en_o` and `periph_clk_en_o` are 1, and `wdg_rst_o`, `ilvl_we_o`, `ilvl_o`, `resume_o` and `resume_irq_o` are 0.
- R2: A `halt_i` strobe sampled while `osc_irq_en_i` is 1 is ignored. All clocks stay on and no watchdog reset is raised.
- R3: A `halt_i` strobe sampled in run while `osc_irq_en_i` is 0 causes a halt entry, unless R5 applies. From the next cycle, `osc_en_o`, `cpu_clk_en_o` and `periph_clk_en_o` are all 0 until wake-up.
- R4: In the first halt cycle `ilvl_we_o` is 1 and `ilvl_o` is binary 10. In every other cycle both are 0.
- R5: If `wdg_en_i` and `wdg_halt_opt_i` are both 1 when a valid halt strobe is sampled, halt is not entered. Instead, `wdg_rst_o` is 1 for exactly the next cycle and all clocks stay on. If `wdg_halt_opt_i` is 0, halt is entered as in R3.
- R6: If a wake source is already present when halt is entered, the controller stays halted for exactly one cycle and then starts stabilisation.
- R7: A bit of `irq_req_i` wakes the controller only when the same bit of `irq_wake_mask_i` is 1. Unmasked requests leave it halted.
- R8: During stabilisation `osc_en_o` is 1 while `cpu_clk_en_o` and `periph_clk_en_o` stay 0. The stabilisation lasts `SHORT_CYC` cycles when `dly_sel_i` was 0 at halt entry, and `LONG_CYC` cycles when it was 1. Later changes of `dly_sel_i` have no effect.
- R9: In the first run cycle after stabilisation, `resume_o` is 1 for one cycle. `resume_irq_o` is 1 with it for an interrupt wake and 0 for a reset wake.
- R10: When `sys_rst_i` and an enabled interrupt request arrive in the same halt cycle, the wake source is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe |
| osc_irq_en_i | input | 1 | Oscillator-interrupt-enable status bit; 1 blocks halt |
| wdg_en_i | input | 1 | Watchdog enabled |
| wdg_halt_opt_i | input | 1 | 1: halt strobe raises watchdog reset; 0: halt normally |
| irq_req_i | input | N_IRQ | Interrupt requests |
| irq_wake_mask_i | input | N_IRQ | 1 marks a request as wake-capable |
| sys_rst_i | input | 1 | External reset request, acts as wake source while halted |
| dly_sel_i | input | 1 | Stabilisation select: 0 short, 1 long |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| ilvl_we_o | output | 1 | Force strobe for the interrupt-level bits |
| ilvl_o | output | 2 | Forced interrupt-level value |
| wdg_rst_o | output | 1 | Watchdog reset request pulse |
| resume_o | output | 1 | One-cycle resume pulse |
| resume_irq_o | output | 1 | With resume: 1 service interrupt, 0 fetch reset vector |

## Verification
The bench builds the controller with `SHORT_CYC` = 6 and `LONG_CYC` = 20 and `N_IRQ` = 8. With these values both stabilisation lengths can be counted cycle by cycle in a short run. This also lets the bench confirm that a `dly_sel_i` change made after entry does not stretch or shorten the count. The bench uses distinct request and mask patterns, so that masked-out requests, the pending-at-entry case and the simultaneous reset-and-interrupt case can each be told apart from an ordinary interrupt wake.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } pwr_state_e;

  localparam logic [1:0] ILVL_HALT = 2'b10;
endpackage

// File: rtl/halt_entry_dec.sv
module halt_entry_dec (
  input  logic halt_i,
  input  logic osc_irq_en_i,
  input  logic wdg_en_i,
  input  logic wdg_halt_opt_i,
  output logic enter_o,
  output logic wdg_trip_o
);
  logic strobe_ok;

  always_comb begin
    strobe_ok  = halt_i & ~osc_irq_en_i;
    wdg_trip_o = strobe_ok & wdg_en_i & wdg_halt_opt_i;
    enter_o    = strobe_ok & ~wdg_trip_o;
  end
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_wake_mask_i,
  input  logic             sys_rst_i,
  output logic             wake_o,
  output logic             src_irq_o
);
  logic irq_hit;

  always_comb begin
    irq_hit   = |(irq_req_i & irq_wake_mask_i);
    wake_o    = sys_rst_i | irq_hit;
    // reset wins over interrupts
    src_irq_o = irq_hit & ~sys_rst_i;
  end
endmodule

// File: rtl/stab_counter.sv
module stab_counter #(
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096,
  localparam int CNT_W    = $clog2(LONG_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? LD_LONG : LD_SHORT;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LD_LONG);
  p_cnt_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
  import halt_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             osc_irq_en_i,
  input  logic             wdg_en_i,
  input  logic             wdg_halt_opt_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_wake_mask_i,
  input  logic             sys_rst_i,
  input  logic             dly_sel_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             ilvl_we_o,
  output logic [1:0]       ilvl_o,
  output logic             wdg_rst_o,
  output logic             resume_o,
  output logic             resume_irq_o
);
  pwr_state_e state_q, state_d;
  logic enter, wdg_trip, wake, src_irq, done;
  logic sel_q, src_irq_q, ilvl_q, wdg_q, resume_q;
  logic load;

  halt_entry_dec u_entry (
    .halt_i        (halt_i),
    .osc_irq_en_i  (osc_irq_en_i),
    .wdg_en_i      (wdg_en_i),
    .wdg_halt_opt_i(wdg_halt_opt_i),
    .enter_o       (enter),
    .wdg_trip_o    (wdg_trip)
  );

  wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req_i      (irq_req_i),
    .irq_wake_mask_i(irq_wake_mask_i),
    .sys_rst_i      (sys_rst_i),
    .wake_o         (wake),
    .src_irq_o      (src_irq)
  );

  assign load = (state_q == ST_HALT) && wake;

  stab_counter #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .long_i(sel_q),
    .run_i (state_q == ST_STAB),
    .done_o(done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (enter) state_d = ST_HALT;
      ST_HALT: if (wake)  state_d = ST_STAB;
      ST_STAB: if (done)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      sel_q     <= 1'b0;
      src_irq_q <= 1'b0;
      ilvl_q    <= 1'b0;
      wdg_q     <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      ilvl_q   <= (state_q == ST_RUN) && enter;
      wdg_q    <= (state_q == ST_RUN) && wdg_trip;
      resume_q <= (state_q == ST_STAB) && done;
      if ((state_q == ST_RUN) && enter) sel_q <= dly_sel_i;
      if (load) src_irq_q <= src_irq;
    end
  end

  assign osc_en_o        = (state_q != ST_HALT);
  assign cpu_clk_en_o    = (state_q == ST_RUN);
  assign periph_clk_en_o = (state_q == ST_RUN);
  assign ilvl_we_o       = ilvl_q;
  assign ilvl_o          = ilvl_q ? ILVL_HALT : 2'b00;
  assign wdg_rst_o       = wdg_q;
  assign resume_o        = resume_q;
  assign resume_irq_o    = resume_q & src_irq_q;

  p_ignore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && halt_i && osc_irq_en_i) |=> (cpu_clk_en_o && !wdg_rst_o));
  p_halt_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && enter) |=> (!osc_en_o && !cpu_clk_en_o && !periph_clk_en_o));
  p_ilvl_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilvl_we_o |-> (ilvl_o == 2'b10 && !osc_en_o));
  p_wdg_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |=> !wdg_rst_o);
  p_wdg_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |-> cpu_clk_en_o);
  p_stab_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && !cpu_clk_en_o) |-> !periph_clk_en_o);
  p_resume_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  p_resume_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_irq_o |-> (resume_o && cpu_clk_en_o));
  p_rst_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && sys_rst_i) |=> (state_q == ST_STAB && !src_irq_q));
endmodule

// File: tb/test_halt_power_ctrl.sv
module test_halt_power_ctrl;
  localparam int N  = 8;
  localparam int SH = 6;
  localparam int LG = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_i = 0, osc_irq_en_i = 0, wdg_en_i = 0, wdg_halt_opt_i = 0;
  logic [N-1:0] irq_req_i = '0, irq_wake_mask_i = '0;
  logic sys_rst_i = 0, dly_sel_i = 0;
  logic osc_en_o, cpu_clk_en_o, periph_clk_en_o, ilvl_we_o, wdg_rst_o, resume_o, resume_irq_o;
  logic [1:0] ilvl_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  halt_power_ctrl #(.N_IRQ(N), .SHORT_CYC(SH), .LONG_CYC(LG)) i_halt_power_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt_i), .osc_irq_en_i(osc_irq_en_i),
    .wdg_en_i(wdg_en_i), .wdg_halt_opt_i(wdg_halt_opt_i), .irq_req_i(irq_req_i),
    .irq_wake_mask_i(irq_wake_mask_i), .sys_rst_i(sys_rst_i), .dly_sel_i(dly_sel_i),
    .osc_en_o(osc_en_o), .cpu_clk_en_o(cpu_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .ilvl_we_o(ilvl_we_o), .ilvl_o(ilvl_o), .wdg_rst_o(wdg_rst_o),
    .resume_o(resume_o), .resume_irq_o(resume_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clocks packed as {osc,cpu,periph}
  function automatic int clks();
    return {29'd0, osc_en_o, cpu_clk_en_o, periph_clk_en_o};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // called on the negedge of the first stabilisation cycle
  task automatic count_stab(input string req, input int exp_len, input int exp_irq);
    int n = 0;
    while (osc_en_o && !cpu_clk_en_o && n < 1000) begin
      if (periph_clk_en_o) chk({req, " periph gated"}, 1, 0);
      n++;
      step();
    end
    chk({req, " stab length"}, n, exp_len);
    chk("R9 resume pulse", resume_o, 1);
    chk("R9 resume source", resume_irq_o, exp_irq);
    step();
    chk("R9 resume single", resume_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    step();
    chk("R1 clocks", clks(), 7);
    chk("R1 outs", {wdg_rst_o, ilvl_we_o, ilvl_o, resume_o, resume_irq_o}, 0);
    rst_ni = 1;
    step();
  endtask

  task automatic t_ignore();
    osc_irq_en_i = 1; halt_i = 1;
    step();
    halt_i = 0; osc_irq_en_i = 0;
    chk("R2 clocks on", clks(), 7);
    chk("R2 no wdg", wdg_rst_o, 0);
    step();
    chk("R2 still run", clks(), 7);
  endtask

  task automatic t_wdg();
    wdg_en_i = 1; wdg_halt_opt_i = 1; halt_i = 1;
    step();
    halt_i = 0;
    chk("R5 wdg pulse", wdg_rst_o, 1);
    chk("R5 clocks on", clks(), 7);
    step();
    chk("R5 wdg single", wdg_rst_o, 0);
    // option cleared: halt normally
    wdg_halt_opt_i = 0; halt_i = 1;
    step();
    halt_i = 0;
    chk("R5 opt0 halts", clks(), 0);
    chk("R5 opt0 no wdg", wdg_rst_o, 0);
    irq_wake_mask_i = 8'h01; irq_req_i = 8'h01;
    step();
    irq_req_i = '0; wdg_en_i = 0;
    count_stab("R8", SH, 1);
  endtask

  task automatic t_irq_short();
    dly_sel_i = 0; halt_i = 1;
    step();
    halt_i = 0;
    chk("R3 all off", clks(), 0);
    chk("R4 ilvl we", ilvl_we_o, 1);
    chk("R4 ilvl val", ilvl_o, 2);
    irq_wake_mask_i = 8'h0F; irq_req_i = 8'hF0; // R7 masked out
    step();
    chk("R4 ilvl once", ilvl_we_o, 0);
    chk("R7 masked stays halted", clks(), 0);
    step();
    chk("R7 still halted", clks(), 0);
    irq_req_i = 8'h04;
    step();
    irq_req_i = '0;
    chk("R8 osc only", clks(), 4);
    count_stab("R8 short", SH, 1);
  endtask

  task automatic t_long();
    dly_sel_i = 1; halt_i = 1;
    step();
    halt_i = 0; dly_sel_i = 0; // change after entry ignored
    irq_wake_mask_i = 8'h80; irq_req_i = 8'h80;
    step();
    irq_req_i = '0;
    count_stab("R8 long", LG, 1);
    // opposite: short selected, raised afterwards
    dly_sel_i = 0; halt_i = 1;
    step();
    halt_i = 0; dly_sel_i = 1;
    irq_req_i = 8'h80;
    step();
    irq_req_i = '0; dly_sel_i = 0;
    count_stab("R8 short held", SH, 1);
  endtask

  task automatic t_pending();
    irq_wake_mask_i = 8'h02; irq_req_i = 8'h02;
    halt_i = 1;
    step();
    halt_i = 0;
    chk("R6 one halt cycle", clks(), 0);
    step();
    chk("R6 stab next", clks(), 4);
    irq_req_i = '0;
    count_stab("R6", SH, 1);
  endtask

  task automatic t_reset_wake();
    halt_i = 1;
    step();
    halt_i = 0;
    sys_rst_i = 1;
    step();
    sys_rst_i = 0;
    chk("R9 reset wake stab", clks(), 4);
    count_stab("R9 reset", SH, 0);
    // simultaneous reset and enabled irq
    irq_wake_mask_i = 8'hFF;
    halt_i = 1;
    step();
    halt_i = 0;
    sys_rst_i = 1; irq_req_i = 8'h10;
    step();
    sys_rst_i = 0; irq_req_i = '0;
    count_stab("R10 prio", SH, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_ignore();
    t_wdg();
    t_irq_short();
    t_long();
    t_pending();
    t_reset_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule